// File: doc/BRIEF.md
# Pattern Match Interrupt Port

This block watches a parallel input port and posts an interrupt when the port shows a pattern that software has set up. Each input bit has three control bits. One says whether the bit takes part in the match. One says whether the bit is judged on a level or on an edge. One says which sense counts: high level or rising edge, or low level or falling edge. A data inversion register flips chosen bits before any of this is judged. A mode field picks how the taking-part bits combine: all of them together (AND), any one of them (OR), or no matching at all.

Inputs pass through a synchroniser. Edges are found by comparing each synchronised sample with the one before it. A match sets an interrupt-pending flag, but only while interrupt-enable is set. A small command register sets and clears interrupt-enable, interrupt-pending and interrupt-under-service, and it holds four general-purpose bits. A dedicated acknowledge strobe clears pending and under-service together, and it works only while enable and pending are both set. The pattern registers are locked while the port is enabled, so software disables the port, rewrites the pattern and then enables it again.

Top module: `pattern_irq_port`

## Requirements
- R1: After reset, interrupt-enable, interrupt-pending, interrupt-under-service, the general-purpose bits and `irq_o` are all 0, and the mode register reads as disabled.
- R2: In OR mode (register address 4, bits [1:0] = 2), a masked level bit (mask at address 0, transition bit at address 1 clear) that reaches the level selected by its polarity bit (address 2: 1 = high, 0 = low) sets interrupt-pending while enable is set. A change on `din` shows on `ip_o` after the third rising clock edge.
- R3: A masked edge bit (transition bit set) posts only on the edge its polarity selects (1 = rising, 0 = falling). The opposite edge, and a level held steady, do not post.
- R4: In AND mode (bits [1:0] = 1), a match needs every masked level bit at its active level. If one masked edge bit exists, its active edge must arrive in the same cycle as those levels.
- R5: A write to mask, transition or mode that would leave AND mode with more than one masked edge bit is discarded, and the earlier configuration stays in force.
- R6: Nothing posts while mode is disabled (0 or 3), while the mask is all zeros, or while `port_en` is low.
- R7: With interrupt-enable clear, a match does not set interrupt-pending. Command 6 sets enable and command 7 clears it.
- R8: A pulse on `ack` clears interrupt-pending and interrupt-under-service only when enable and pending are both set. Otherwise it changes nothing.
- R9: A level condition that persists posts pending again on the clock after software clears it. An edge condition does not post again.
- R10: Register address 3 inverts the selected input bits before matching, and `pins_o` shows the inverted synchronised value. Its reset value inverts bit 7 only.
- R11: Writes to addresses 0 to 4 are ignored while `port_en` is high.
- R12: `irq_o` is high exactly when enable and pending are set and under-service is clear. Command 2 sets under-service, command 3 clears it, command 4 sets pending, command 5 clears pending, and command 1 clears pending and under-service.
- R13: A write to address 5 carries the command code in bits [7:5] and loads bits [3:0] into the general-purpose bits. An acknowledge leaves those bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Port enable; allows matching and locks the pattern registers |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (0 mask, 1 transition, 2 polarity, 3 inversion, 4 mode, 5 command) |
| cfg_wdata | input | WIDTH | Register write data |
| ack | input | 1 | Interrupt acknowledge strobe |
| din | input | WIDTH | Asynchronous port inputs |
| ie_o | output | 1 | Interrupt-enable flag |
| ip_o | output | 1 | Interrupt-pending flag |
| ius_o | output | 1 | Interrupt-under-service flag |
| gp_o | output | 4 | General-purpose command register bits |
| irq_o | output | 1 | Interrupt request |
| pins_o | output | WIDTH | Synchronised, inverted port value |

## Verification
The hardest case to reach from the ports is AND mode, where the single edge bit must show its active edge in the same cycle that every level bit is already active. The bench reaches it by first settling the level bits with the edge bit idle and clearing any stale pending flag. It then flips only the edge bit. It also tries the reverse order, where the edge arrives while a level bit is low, and it tries levels that are held after the edge has passed. Rejected AND configurations are checked through behaviour: the bench attempts the illegal write and then uses a stimulus whose outcome differs between the old and the new configuration.

// File: rtl/pim_pkg.sv
package pim_pkg;

   typedef enum logic [1:0] {
      PM_OFF = 2'd0,
      PM_AND = 2'd1,
      PM_OR  = 2'd2,
      PM_RSV = 2'd3
   } pmode_e;

   typedef enum logic [2:0] {
      CMD_NOP        = 3'd0,
      CMD_CLR_IP_IUS = 3'd1,
      CMD_SET_IUS    = 3'd2,
      CMD_CLR_IUS    = 3'd3,
      CMD_SET_IP     = 3'd4,
      CMD_CLR_IP     = 3'd5,
      CMD_SET_IE     = 3'd6,
      CMD_CLR_IE     = 3'd7
   } cmd_e;

   localparam int ADDR_W  = 3;
   localparam int GP_W    = 4;
   localparam int CMD_LSB = 5;
   localparam int CMD_W   = 3;

   localparam logic [ADDR_W-1:0] A_MASK  = 3'd0;
   localparam logic [ADDR_W-1:0] A_TRANS = 3'd1;
   localparam logic [ADDR_W-1:0] A_POL   = 3'd2;
   localparam logic [ADDR_W-1:0] A_INV   = 3'd3;
   localparam logic [ADDR_W-1:0] A_MODE  = 3'd4;
   localparam logic [ADDR_W-1:0] A_CMD   = 3'd5;

endpackage

// File: rtl/pim_sync.sv
module pim_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] d_sync
);

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d_async;
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[k] <= '0;
         else        stg[k] <= stg[k-1];
      end
   end

   assign d_sync = stg[STAGES-1];

endmodule

// File: rtl/pim_cfg_regs.sv
module pim_cfg_regs
   import pim_pkg::*;
#(
   parameter int               WIDTH   = 8,
   parameter int               EDGE_MAX = 1,
   parameter logic [WIDTH-1:0] INV_RST = 8'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_en,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0]  wdata,
   output logic [WIDTH-1:0]  mask_q,
   output logic [WIDTH-1:0]  trans_q,
   output logic [WIDTH-1:0]  pol_q,
   output logic [WIDTH-1:0]  inv_q,
   output pmode_e            mode_q
);

   localparam int CNT_W = $clog2(WIDTH + 1);

   function automatic logic [CNT_W-1:0] popcnt(input logic [WIDTH-1:0] v);
      logic [CNT_W-1:0] n;
      n = '0;
      for (int i = 0; i < WIDTH; i++) n = n + CNT_W'(v[i]);
      return n;
   endfunction

   logic [WIDTH-1:0] cand_mask;
   logic [WIDTH-1:0] cand_trans;
   pmode_e           cand_mode;
   logic             legal;
   logic             upd;

   always_comb begin
      cand_mask  = mask_q;
      cand_trans = trans_q;
      cand_mode  = mode_q;
      if (we) begin
         case (addr)
            A_MASK:  cand_mask  = wdata;
            A_TRANS: cand_trans = wdata;
            A_MODE:  cand_mode  = pmode_e'(wdata[1:0]);
            default: ;
         endcase
      end
      legal = !((cand_mode == PM_AND) &&
                (popcnt(cand_mask & cand_trans) > CNT_W'(EDGE_MAX)));
      upd   = we && !port_en && legal;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '0;
         trans_q <= '0;
         pol_q   <= '0;
         inv_q   <= INV_RST;
         mode_q  <= PM_OFF;
      end else if (upd) begin
         case (addr)
            A_MASK:  mask_q  <= wdata;
            A_TRANS: trans_q <= wdata;
            A_POL:   pol_q   <= wdata;
            A_INV:   inv_q   <= wdata;
            A_MODE:  mode_q  <= pmode_e'(wdata[1:0]);
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/pim_match.sv
module pim_match
   import pim_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             port_en,
   input  logic [WIDTH-1:0] s_cur,
   input  logic [WIDTH-1:0] mask,
   input  logic [WIDTH-1:0] trans,
   input  logic [WIDTH-1:0] pol,
   input  pmode_e           mode,
   output logic             hit
);

   logic [WIDTH-1:0] s_prev;
   logic [WIDTH-1:0] cond;
   logic             all_ok;
   logic             any_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s_prev <= '0;
      else        s_prev <= s_cur;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic lvl_ok;
      logic edg_ok;
      assign lvl_ok  = ~(s_cur[i] ^ pol[i]);
      assign edg_ok  = pol[i] ? (s_cur[i] & ~s_prev[i]) : (~s_cur[i] & s_prev[i]);
      assign cond[i] = trans[i] ? edg_ok : lvl_ok;
   end

   assign all_ok = &(cond | ~mask);
   assign any_ok = |(cond & mask);

   always_comb begin
      hit = 1'b0;
      if (port_en && (|mask)) begin
         case (mode)
            PM_AND:  hit = all_ok;
            PM_OR:   hit = any_ok;
            default: hit = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/pim_irq_flags.sv
module pim_irq_flags
   import pim_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_we,
   input  cmd_e            cmd_code,
   input  logic [GP_W-1:0] cmd_gp,
   input  logic            ack,
   input  logic            hit,
   output logic            ie_q,
   output logic            ip_q,
   output logic            ius_q,
   output logic [GP_W-1:0] gp_q
);

   logic ack_ok;
   logic ip_clr, ip_set;
   logic ius_clr, ius_set;
   logic ie_clr, ie_set;

   always_comb begin
      ack_ok  = ack && ie_q && ip_q;
      ip_clr  = ack_ok || (cmd_we && (cmd_code == CMD_CLR_IP_IUS || cmd_code == CMD_CLR_IP));
      ip_set  = (cmd_we && cmd_code == CMD_SET_IP) || (hit && ie_q);
      ius_clr = ack_ok || (cmd_we && (cmd_code == CMD_CLR_IP_IUS || cmd_code == CMD_CLR_IUS));
      ius_set = cmd_we && cmd_code == CMD_SET_IUS;
      ie_clr  = cmd_we && cmd_code == CMD_CLR_IE;
      ie_set  = cmd_we && cmd_code == CMD_SET_IE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q  <= 1'b0;
         ip_q  <= 1'b0;
         ius_q <= 1'b0;
         gp_q  <= '0;
      end else begin
         if (ip_clr)       ip_q <= 1'b0;
         else if (ip_set)  ip_q <= 1'b1;
         if (ius_clr)      ius_q <= 1'b0;
         else if (ius_set) ius_q <= 1'b1;
         if (ie_clr)       ie_q <= 1'b0;
         else if (ie_set)  ie_q <= 1'b1;
         if (cmd_we)       gp_q <= cmd_gp;
      end
   end

endmodule

// File: rtl/pattern_irq_port.sv
module pattern_irq_port
   import pim_pkg::*;
#(
   parameter int               WIDTH       = 8,
   parameter int               SYNC_STAGES = 2,
   parameter int               EDGE_MAX    = 1,
   parameter logic [WIDTH-1:0] INV_RST     = 8'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_en,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [WIDTH-1:0]  cfg_wdata,
   input  logic              ack,
   input  logic [WIDTH-1:0]  din,
   output logic              ie_o,
   output logic              ip_o,
   output logic              ius_o,
   output logic [GP_W-1:0]   gp_o,
   output logic              irq_o,
   output logic [WIDTH-1:0]  pins_o
);

   if (WIDTH < CMD_LSB + CMD_W) begin : g_bad_width
      $error("pattern_irq_port: WIDTH must hold the command field");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pattern_irq_port: SYNC_STAGES must be at least 2");
   end
   if (EDGE_MAX < 1 || EDGE_MAX > WIDTH) begin : g_bad_edge
      $error("pattern_irq_port: EDGE_MAX out of range");
   end

   logic [WIDTH-1:0] mask_q, trans_q, pol_q, inv_q;
   pmode_e           mode_q;
   logic [WIDTH-1:0] raw_sync;
   logic [WIDTH-1:0] s_cur;
   logic             hit;
   logic             cmd_we;
   cmd_e             cmd_code;
   logic             unused_wbit;

   pim_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (din),
      .d_sync  (raw_sync)
   );

   pim_cfg_regs #(.WIDTH(WIDTH), .EDGE_MAX(EDGE_MAX), .INV_RST(INV_RST)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .port_en (port_en),
      .we      (cfg_we),
      .addr    (cfg_addr),
      .wdata   (cfg_wdata),
      .mask_q  (mask_q),
      .trans_q (trans_q),
      .pol_q   (pol_q),
      .inv_q   (inv_q),
      .mode_q  (mode_q)
   );

   assign s_cur = raw_sync ^ inv_q;

   pim_match #(.WIDTH(WIDTH)) u_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .port_en (port_en),
      .s_cur   (s_cur),
      .mask    (mask_q),
      .trans   (trans_q),
      .pol     (pol_q),
      .mode    (mode_q),
      .hit     (hit)
   );

   assign cmd_we      = cfg_we && (cfg_addr == A_CMD);
   assign cmd_code    = cmd_e'(cfg_wdata[CMD_LSB +: CMD_W]);
   assign unused_wbit = cfg_wdata[GP_W];

   pim_irq_flags u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_we   (cmd_we),
      .cmd_code (cmd_code),
      .cmd_gp   (cfg_wdata[GP_W-1:0]),
      .ack      (ack),
      .hit      (hit),
      .ie_q     (ie_o),
      .ip_q     (ip_o),
      .ius_q    (ius_o),
      .gp_q     (gp_o)
   );

   assign irq_o  = ie_o && ip_o && !ius_o;
   assign pins_o = s_cur;

endmodule

// File: rtl/pim_checker.sv
module pim_checker
   import pim_pkg::*;
#(
   parameter int WIDTH    = 8,
   parameter int EDGE_MAX = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              port_en,
   input logic              cfg_we,
   input logic [ADDR_W-1:0] cfg_addr,
   input logic [WIDTH-1:0]  cfg_wdata,
   input logic              ack,
   input logic              ie_o,
   input logic              ip_o,
   input logic              ius_o,
   input logic [GP_W-1:0]   gp_o,
   input logic [WIDTH-1:0]  mask_q,
   input logic [WIDTH-1:0]  trans_q,
   input logic [WIDTH-1:0]  pol_q,
   input logic [WIDTH-1:0]  inv_q,
   input pmode_e            mode_q
);

   logic set_ip_cmd;
   logic unused_chk;

   assign set_ip_cmd = cfg_we && (cfg_addr == A_CMD) &&
                       (cfg_wdata[CMD_LSB +: CMD_W] == CMD_SET_IP);
   assign unused_chk = ^cfg_wdata;

   AST_AND_EDGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PM_AND) |-> ($countones(mask_q & trans_q) <= EDGE_MAX)); // R5

   AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      port_en |=> ($stable(mask_q) && $stable(trans_q) && $stable(pol_q) &&
                   $stable(inv_q) && $stable(mode_q))); // R11

   AST_NO_POST_WITHOUT_IE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ip_o && !ie_o && !set_ip_cmd) |=> !ip_o); // R7

   AST_ZERO_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((mask_q == '0) && !ip_o && !set_ip_cmd) |=> !ip_o); // R6

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && ie_o && ip_o) |=> (!ip_o && !ius_o)); // R8

   AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !(ie_o && ip_o) && !cfg_we) |=>
         ((ius_o == $past(ius_o)) && (!$past(ip_o) || ip_o))); // R8

   AST_ACK_KEEPS_GP: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !cfg_we) |=> $stable(gp_o)); // R13

endmodule

bind pattern_irq_port pim_checker #(.WIDTH(WIDTH), .EDGE_MAX(EDGE_MAX)) u_pim_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .port_en   (port_en),
   .cfg_we    (cfg_we),
   .cfg_addr  (cfg_addr),
   .cfg_wdata (cfg_wdata),
   .ack       (ack),
   .ie_o      (ie_o),
   .ip_o      (ip_o),
   .ius_o     (ius_o),
   .gp_o      (gp_o),
   .mask_q    (mask_q),
   .trans_q   (trans_q),
   .pol_q     (pol_q),
   .inv_q     (inv_q),
   .mode_q    (mode_q)
);

// File: tb/test_pattern_irq_port.sv
module test_pattern_irq_port;
   import pim_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         port_en;
   logic         cfg_we;
   logic [2:0]   cfg_addr;
   logic [W-1:0] cfg_wdata;
   logic         ack;
   logic [W-1:0] din;
   logic         ie_o, ip_o, ius_o, irq_o;
   logic [3:0]   gp_o;
   logic [W-1:0] pins_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pattern_irq_port i_pattern_irq_port (
      .clk(clk), .rst_n(rst_n), .port_en(port_en), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .ack(ack), .din(din),
      .ie_o(ie_o), .ip_o(ip_o), .ius_o(ius_o), .gp_o(gp_o),
      .irq_o(irq_o), .pins_o(pins_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cmd(input logic [2:0] code, input logic [3:0] gp);
      wr(3'd5, {code, 1'b0, gp});
   endtask

   task automatic pulse_ack();
      @(negedge clk);
      ack = 1'b1;
      @(posedge clk);
      @(negedge clk);
      ack = 1'b0;
   endtask

   task automatic settle();
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic setup(input logic [W-1:0] m, t, p, inv, input logic [1:0] md);
      @(negedge clk);
      port_en = 1'b0;
      wr(3'd4, 8'h00);
      wr(3'd0, m);
      wr(3'd1, t);
      wr(3'd2, p);
      wr(3'd3, inv);
      wr(3'd4, {6'd0, md});
      port_en = 1'b1;
   endtask

   task automatic arm();
      settle();
      cmd(3'd1, 4'h0);
      cmd(3'd6, 4'h0);
   endtask

   task automatic report();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R1 watchdog actual timeout expected completion");
      report();
      $finish;
   end

   initial begin
      rst_n = 1'b0; port_en = 1'b0; cfg_we = 1'b0; cfg_addr = '0;
      cfg_wdata = '0; ack = 1'b0; din = '0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      settle();
      // R1: flags cleared after reset
      chk("R1 ie", ie_o, 0);
      chk("R1 ip", ip_o, 0);
      chk("R1 ius", ius_o, 0);
      chk("R1 gp", gp_o, 0);
      chk("R1 irq", irq_o, 0);
      // R10: reset inversion covers bit 7 only
      chk("R10 reset view", pins_o, 8'h80);
      // R1: mode disabled at reset; mask set, mode untouched, input active
      port_en = 1'b0;
      wr(3'd0, 8'h01); wr(3'd2, 8'h01);
      port_en = 1'b1;
      din = 8'h01;
      arm(); settle();
      chk("R1 mode off", ip_o, 0);

      // R2: level sweep over every bit and both senses
      for (int b = 0; b < W; b++) begin
         for (int p = 0; p < 2; p++) begin
            logic [W-1:0] bm;
            bm = W'(1) << b;
            setup(bm, 8'h00, (p != 0) ? bm : 8'h00, 8'h00, 2'd2);
            din = (p != 0) ? 8'h00 : 8'hFF;
            arm();
            chk("R2 idle level", ip_o, 0);
            din = din ^ bm;
            settle();
            chk("R2 active level", ip_o, 1);
         end
      end

      // R3 / R9: edge sweep over every bit and both senses
      for (int b = 0; b < W; b++) begin
         for (int p = 0; p < 2; p++) begin
            logic [W-1:0] bm;
            bm = W'(1) << b;
            setup(bm, bm, (p != 0) ? bm : 8'h00, 8'h00, 2'd2);
            din = (p != 0) ? 8'h00 : 8'hFF;
            arm();
            chk("R3 idle edge", ip_o, 0);
            din = din ^ bm;
            settle();
            chk("R3 active edge", ip_o, 1);
            cmd(3'd5, 4'h0);
            settle();
            chk("R9 edge no repost", ip_o, 0);
            din = din ^ bm;
            settle();
            chk("R3 wrong edge", ip_o, 0);
         end
      end

      // R9: persistent level posts again one clock after clear
      setup(8'h01, 8'h00, 8'h01, 8'h00, 2'd2);
      din = 8'h01;
      arm(); settle();
      chk("R9 level posted", ip_o, 1);
      cmd(3'd5, 4'h0);
      chk("R9 cleared", ip_o, 0);
      @(posedge clk); @(negedge clk);
      chk("R9 reposted", ip_o, 1);

      // R4: AND mode with one edge bit and one level bit
      for (int e = 0; e < W; e++) begin
         logic [W-1:0] be, bl;
         be = W'(1) << e;
         bl = W'(1) << ((e + 3) % W);
         setup(be | bl, be, 8'hFF, 8'h00, 2'd1);
         din = 8'h00;
         arm();
         din = be;
         settle();
         chk("R4 edge without level", ip_o, 0);
         din = bl;
         arm();
         chk("R4 level without edge", ip_o, 0);
         din = be | bl;
         settle();
         chk("R4 edge with level", ip_o, 1);
         cmd(3'd5, 4'h0);
         settle();
         chk("R4 levels held after edge", ip_o, 0);
      end
      // R4: AND with levels only
      setup(8'h0F, 8'h00, 8'h05, 8'h00, 2'd1);
      din = 8'h04;
      arm();
      chk("R4 levels partial", ip_o, 0);
      din = 8'h05;
      settle();
      chk("R4 levels all", ip_o, 1);

      // R5: illegal mode write discarded, OR mode stays
      setup(8'h03, 8'h03, 8'h03, 8'h00, 2'd2);
      port_en = 1'b0;
      wr(3'd4, 8'h01);
      port_en = 1'b1;
      din = 8'h00;
      arm();
      din = 8'h01;
      settle();
      chk("R5 mode write rejected", ip_o, 1);
      // R5: illegal transition write discarded in AND mode
      setup(8'h03, 8'h01, 8'h03, 8'h00, 2'd1);
      port_en = 1'b0;
      wr(3'd1, 8'h03);
      port_en = 1'b1;
      din = 8'h02;
      arm();
      chk("R5 idle", ip_o, 0);
      din = 8'h03;
      settle();
      chk("R5 transition write rejected", ip_o, 1);

      // R6: disabled and reserved modes, zero mask, port disabled
      setup(8'hFF, 8'h00, 8'hFF, 8'h00, 2'd0);
      din = 8'hFF;
      arm(); settle();
      chk("R6 mode off", ip_o, 0);
      setup(8'hFF, 8'h00, 8'hFF, 8'h00, 2'd3);
      arm(); settle();
      chk("R6 mode reserved", ip_o, 0);
      setup(8'h00, 8'h00, 8'hFF, 8'h00, 2'd2);
      din = 8'h00;
      arm();
      din = 8'hFF;
      settle();
      chk("R6 zero mask", ip_o, 0);
      setup(8'h01, 8'h00, 8'h01, 8'h00, 2'd2);
      din = 8'h00;
      arm();
      port_en = 1'b0;
      din = 8'h01;
      settle();
      chk("R6 port disabled", ip_o, 0);
      port_en = 1'b1;
      settle();
      chk("R6 port enabled", ip_o, 1);

      // R11: mask write while enabled is ignored
      setup(8'h01, 8'h00, 8'h03, 8'h00, 2'd2);
      wr(3'd0, 8'h02);
      din = 8'h02;
      arm(); settle();
      chk("R11 locked mask", ip_o, 0);
      din = 8'h03;
      settle();
      chk("R11 old mask live", ip_o, 1);

      // R7: enable gates posting
      setup(8'h01, 8'h00, 8'h01, 8'h00, 2'd2);
      din = 8'h00;
      arm();
      cmd(3'd7, 4'h0);
      chk("R7 ie cleared", ie_o, 0);
      din = 8'h01;
      settle();
      chk("R7 no post without ie", ip_o, 0);
      cmd(3'd6, 4'h0);
      settle();
      chk("R7 post after ie", ip_o, 1);

      // R10: inversion register and view port
      setup(8'h80, 8'h00, 8'h80, 8'h80, 2'd2);
      din = 8'h00;
      arm(); settle();
      chk("R10 inverted bit7 active", ip_o, 1);
      setup(8'h80, 8'h00, 8'h80, 8'h00, 2'd2);
      arm(); settle();
      chk("R10 no inversion", ip_o, 0);
      for (int v = 0; v < 4; v++) begin
         logic [W-1:0] iv;
         iv = W'(8'h5A) << v;
         setup(8'h00, 8'h00, 8'h00, iv, 2'd0);
         din = W'(8'h33) ^ W'(v * 8'h11);
         settle();
         chk("R10 view", pins_o, din ^ iv);
      end

      // R8 / R12 / R13: flag commands and acknowledge
      setup(8'h00, 8'h00, 8'h00, 8'h00, 2'd0);
      cmd(3'd1, 4'hA);
      cmd(3'd6, 4'hA);
      chk("R13 gp load", gp_o, 4'hA);
      cmd(3'd4, 4'hA);
      chk("R12 set ip", ip_o, 1);
      chk("R12 irq high", irq_o, 1);
      cmd(3'd2, 4'hA);
      chk("R12 set ius", ius_o, 1);
      chk("R12 irq masked by ius", irq_o, 0);
      cmd(3'd3, 4'hA);
      chk("R12 clr ius irq", irq_o, 1);
      cmd(3'd2, 4'hA);
      pulse_ack();
      chk("R8 ack clears ip", ip_o, 0);
      chk("R8 ack clears ius", ius_o, 0);
      chk("R13 gp kept by ack", gp_o, 4'hA);
      cmd(3'd7, 4'h5);
      cmd(3'd4, 4'h5);
      cmd(3'd2, 4'h5);
      pulse_ack();
      chk("R8 ack ignored ip", ip_o, 1);
      chk("R8 ack ignored ius", ius_o, 1);
      chk("R12 irq needs ie", irq_o, 0);
      cmd(3'd5, 4'h5);
      cmd(3'd6, 4'h5);
      pulse_ack();
      chk("R8 ack without ip", ius_o, 1);
      chk("R13 gp second value", gp_o, 4'h5);

      report();
      $finish;
   end

endmodule